// File: doc/BRIEF.md
# Descriptor commit port

This block is the write side of a scatter-gather DMA dispatcher. A host builds an eight-word extended descriptor through a 32-bit word-addressed write port. The words hold the read and write addresses, each split into a low and a high half, plus the length, the burst and sequence word, the stride word and the control word. The seven data words are kept in shadow registers. A write of the control word with its commit bit (bit 31) set pushes one entry into a descriptor FIFO. That entry is the seven shadows together with the control value just written. The descriptor at the FIFO head goes to a downstream mover over a valid/ready handshake.

The block does not decode the fields inside the words. The burst/sequence word carries the write burst in [31:24], the read burst in [23:16] and the sequence number in [15:0], where a burst of 0 means the largest burst. The stride word carries the write stride in [31:16] and the read stride in [15:0], where 1 means incrementing addresses and 0 means a fixed address. The control word carries the channel in [7:0] and the packet, park, end-condition and interrupt enables in [24:8]. These layouts pass through unchanged, except for the commit bit, which is cleared. A host polls the full flag, the empty flag and the fill-level word before it commits. A commit that arrives while the FIFO is full is refused and recorded in a sticky flag.

Top module: `dsc_commit_port`

## Requirements
- R1: Word index `wr_idx` selects the descriptor word to write. The indices are 0 read-address low, 1 write-address low, 2 length, 3 burst/sequence, 4 stride, 5 read-address high, 6 write-address high and 7 control. On `out_desc`, word i occupies bits [32*i+31:32*i].
- R2: A write to indices 0 to 6 only updates that word's shadow register and never adds a FIFO entry.
- R3: A write to index 7 with bit 31 set pushes, at that clock edge, one entry made of the current shadows 0 to 6 and the written control value. The entry is visible at the FIFO head after the same edge if the FIFO was empty.
- R4: A write to index 7 with bit 31 clear adds no entry.
- R5: The control word on `out_desc` always has bit 31 cleared. All other control bits are kept as written.
- R6: Entries leave in commit order. The FIFO holds up to DEPTH entries. A push and a pop in the same cycle leave the count unchanged.
- R7: `desc_full` and `desc_empty` are registered. After each edge they show whether the count is DEPTH or 0.
- R8: A commit while `desc_full` is high is dropped, and `overflow` is set and stays set until reset. The shadow registers are not disturbed by the dropped commit.
- R9: `out_valid` is high whenever the FIFO holds an entry. While `out_ready` is low, `out_valid` and `out_desc` hold steady. An entry is removed at an edge where both are high.
- R10: `fill_level` reports the entry count zero-extended into both [31:16] (write side) and [15:0] (read side).
- R11: After reset the FIFO is empty, `out_valid` and `overflow` are low and `fill_level` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host word write strobe |
| wr_idx | input | 3 | Descriptor word index |
| wr_data | input | 32 | Host write data |
| out_valid | output | 1 | Head descriptor available |
| out_ready | input | 1 | Consumer accepts the head descriptor |
| out_desc | output | 256 | Head descriptor, eight words, commit bit cleared |
| desc_full | output | 1 | FIFO holds DEPTH entries |
| desc_empty | output | 1 | FIFO holds no entry |
| overflow | output | 1 | Sticky: a commit was refused while full |
| fill_level | output | 32 | Entry count in both 16-bit halves |

## Verification
The bench builds the block with DEPTH set to 3. With that depth the FIFO fills after three commits, so every round reaches the full condition, the refused commit and the drain back to empty. Three rounds with different word patterns move both pointers through every slot and across the wrap point several times. The bench also covers a commit that lands in the same cycle as a pop while one entry is held.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
    localparam int WORD_W    = 32;
    localparam int NUM_WORDS = 8;
    localparam int IDX_W     = $clog2(NUM_WORDS);
    localparam int GO_POS    = 31;

    typedef enum logic [IDX_W-1:0] {
        W_SRC_LO = 3'd0,
        W_DST_LO = 3'd1,
        W_LEN    = 3'd2,
        W_BURST  = 3'd3,
        W_STRIDE = 3'd4,
        W_SRC_HI = 3'd5,
        W_DST_HI = 3'd6,
        W_CTRL   = 3'd7
    } word_idx_e;

    // Packed with word 0 in the least significant position.
    typedef struct packed {
        logic [WORD_W-1:0] ctrl;
        logic [WORD_W-1:0] dst_hi;
        logic [WORD_W-1:0] src_hi;
        logic [WORD_W-1:0] stride;
        logic [WORD_W-1:0] burst_seq;
        logic [WORD_W-1:0] len;
        logic [WORD_W-1:0] dst_lo;
        logic [WORD_W-1:0] src_lo;
    } desc_t;

    localparam int DESC_W = $bits(desc_t);

    function automatic logic [WORD_W-1:0] strip_go(input logic [WORD_W-1:0] w);
        logic [WORD_W-1:0] r;
        r         = w;
        r[GO_POS] = 1'b0;
        return r;
    endfunction
endpackage

// File: rtl/dsc_stage.sv
module dsc_stage
    import dsc_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [IDX_W-1:0]    wr_idx,
    input  logic [WORD_W-1:0]   wr_data,
    output logic                commit,
    output desc_t               entry
);
    localparam int NSHADOW = NUM_WORDS - 1;

    logic [NSHADOW-1:0][WORD_W-1:0] shadow;
    logic is_ctrl;

    assign is_ctrl = (word_idx_e'(wr_idx) == W_CTRL);

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow <= '0;
        end else if (wr_en && !is_ctrl) begin
            shadow[wr_idx] <= wr_data;
        end
    end

    assign commit = wr_en && is_ctrl && wr_data[GO_POS];
    assign entry  = desc_t'({strip_go(wr_data), shadow});
endmodule

// File: rtl/dsc_fifo.sv
module dsc_fifo
    import dsc_pkg::*;
#(
    parameter  int DEPTH = 4,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  desc_t            din,
    input  logic             pop,
    output desc_t            dout,
    output logic             full,
    output logic             empty,
    output logic [CNT_W-1:0] count
);
    desc_t            mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             push_ok, pop_ok;
    logic [CNT_W-1:0] cnt_nxt;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign cnt_nxt = count + CNT_W'(push_ok) - CNT_W'(pop_ok);

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            full   <= 1'b0;
            empty  <= 1'b1;
        end else begin
            if (push_ok) wr_ptr <= bump(wr_ptr);
            if (pop_ok)  rd_ptr <= bump(rd_ptr);
            count <= cnt_nxt;
            full  <= (cnt_nxt == CNT_W'(DEPTH));
            empty <= (cnt_nxt == '0);
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= din;
    end

    assign dout = mem[rd_ptr];

    AST_FULL_EMPTY_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(full && empty)); // R7
    AST_FULL_BLOCKS_PUSH: assert property (@(posedge clk) disable iff (rst)
        (full && !pop) |=> (count == $past(count))); // R8
    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(DEPTH)); // R6
endmodule

// File: rtl/dsc_commit_port.sv
module dsc_commit_port
    import dsc_pkg::*;
#(
    parameter  int DEPTH = 4,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int LVL_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [2:0]        wr_idx,
    input  logic [31:0]       wr_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [255:0]      out_desc,
    output logic              desc_full,
    output logic              desc_empty,
    output logic              overflow,
    output logic [31:0]       fill_level
);
    logic             commit;
    desc_t            entry, head;
    logic [CNT_W-1:0] count;

    dsc_stage u_stage (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .commit  (commit),
        .entry   (entry)
    );

    dsc_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .push  (commit),
        .din   (entry),
        .pop   (out_ready),
        .dout  (head),
        .full  (desc_full),
        .empty (desc_empty),
        .count (count)
    );

    always_ff @(posedge clk) begin
        if (rst)                       overflow <= 1'b0;
        else if (commit && desc_full)  overflow <= 1'b1;
    end

    assign out_valid  = !desc_empty;
    assign out_desc   = head;
    assign fill_level = {LVL_W'(count), LVL_W'(count)};

    AST_VALID_HOLD: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_desc))); // R9
    AST_GO_CLEAR: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !out_desc[DESC_W-1]); // R5
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow); // R8
    AST_DATA_NO_PUSH: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_idx != 3'd7 && !(out_valid && out_ready))
            |=> (fill_level == $past(fill_level))); // R2
endmodule

// File: tb/dsc_commit_port_test.sv
module dsc_commit_port_test;
    localparam int DEPTH = 3;
    localparam logic [31:0] GO = 32'h8000_0000;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         wr_en = 1'b0;
    logic [2:0]   wr_idx = '0;
    logic [31:0]  wr_data = '0;
    logic         out_ready = 1'b0;
    logic         out_valid, desc_full, desc_empty, overflow;
    logic [255:0] out_desc;
    logic [31:0]  fill_level;

    int errs = 0;
    int checks = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    dsc_commit_port #(.DEPTH(DEPTH)) uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_desc(out_desc),
        .desc_full(desc_full), .desc_empty(desc_empty), .overflow(overflow),
        .fill_level(fill_level)
    );

    task automatic chk(input bit ok, input string req, input logic [255:0] act,
                       input logic [255:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] wv(input int e, input int w);
        return {4'(w), 4'(e), 8'(e * 29 + w), 16'(e * 977 + w * 131 + 7)};
    endfunction

    function automatic logic [255:0] expd(input int e, input int ce);
        logic [255:0] d;
        for (int w = 0; w < 7; w++) d[32*w +: 32] = wv(e, w);
        d[255:224] = wv(ce, 7) & ~GO;
        return d;
    endfunction

    function automatic logic [31:0] lvl(input int n);
        return {16'(n), 16'(n)};
    endfunction

    task automatic put(input int idx, input logic [31:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 3'(idx); wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic stage_words(input int e);
        for (int w = 0; w < 7; w++) put(w, wv(e, w));
    endtask

    task automatic take();
        @(negedge clk);
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errs++; checks++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R11 reset state
        chk(desc_empty && !desc_full && !out_valid && !overflow, "R11 flags",
            {desc_empty, desc_full, out_valid, overflow}, 4'b1000);
        chk(fill_level == 32'd0, "R11 level", fill_level, 0);

        for (int r = 0; r < 3; r++) begin
            int base = r * 10;
            stage_words(base);
            chk(fill_level == 0 && !out_valid, "R2 data words push nothing", fill_level, 0);
            put(7, wv(base, 7) & ~GO);
            chk(fill_level == 0 && desc_empty, "R4 control without go", fill_level, 0);
            put(7, wv(base, 7) | GO);
            chk(out_valid && fill_level == lvl(1), "R3 commit visible", fill_level, lvl(1));
            chk(out_desc == expd(base, base), "R1 R5 word layout, go cleared", out_desc, expd(base, base));
            for (int k = 1; k < DEPTH; k++) begin
                stage_words(base + k);
                put(7, wv(base + k, 7) | GO);
                chk(fill_level == lvl(k + 1), "R10 level halves", fill_level, lvl(k + 1));
                chk(desc_full == (k + 1 == DEPTH) && !desc_empty, "R7 full flag",
                    desc_full, (k + 1 == DEPTH));
            end
            stage_words(base + 9);
            put(7, wv(base + 9, 7) | GO);
            chk(fill_level == lvl(DEPTH), "R8 dropped commit", fill_level, lvl(DEPTH));
            chk(overflow == 1'b1, "R8 overflow sticky", overflow, 1);
            repeat (2) @(negedge clk);
            chk(out_valid && out_desc == expd(base, base), "R9 hold while not ready",
                out_desc, expd(base, base));
            for (int k = 0; k < DEPTH; k++) begin
                chk(out_desc == expd(base + k, base + k), "R6 order", out_desc,
                    expd(base + k, base + k));
                take();
                chk(fill_level == lvl(DEPTH - 1 - k), "R9 pop", fill_level, lvl(DEPTH - 1 - k));
            end
            chk(desc_empty && !desc_full && !out_valid, "R7 empty after drain",
                {desc_empty, desc_full}, 2'b10);
            put(7, wv(base + 9, 7) | GO);
            chk(out_desc == expd(base + 9, base + 9), "R8 shadows intact", out_desc,
                expd(base + 9, base + 9));
            @(negedge clk);
            wr_en = 1'b1; wr_idx = 3'd7; wr_data = wv(base + 8, 7) | GO; out_ready = 1'b1;
            @(negedge clk);
            wr_en = 1'b0; out_ready = 1'b0;
            chk(fill_level == lvl(1), "R6 push with pop", fill_level, lvl(1));
            chk(out_desc == expd(base + 9, base + 8), "R6 push with pop data", out_desc,
                expd(base + 9, base + 8));
            take();
            chk(desc_empty && overflow, "R8 flag kept, drained", {desc_empty, overflow}, 2'b11);
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule